// File: doc/BRIEF.md
# Dual-Port RAM with Selectable Write Behaviour

A synchronous memory with two fully independent ports, each on its own clock. Either port can read or write any location. Each stored word is a main data field plus a few side-band bits. The side-band bits are kept and returned exactly like data, and nothing computes or checks them. Every port owns a registered output. A per-port mode parameter decides what that output shows while the port is writing: the new word, the word that was there before, or an unchanged value.

A per-port synchronous set/reset input loads the output register with a parameterised constant. This gives a known value on the read path without touching the array. The capacity is fixed in data bits, so the word count and the address width follow from the data width. When one port touches an address in the same cycle that the other port writes it, that port raises a collision flag. The word read in that cycle is then not defined.

Top module: `dual_port_mode_ram`

## Requirements
- R1: While `rst_x` is high at a clock edge of port x, `dout_x`/`doutx_x` take that port's initial constant (`{side,data}`, default A = 36'hA_5A5A_0F0F, B = 36'h3_C3C3_1234) and `coll_x` goes low.
- R2: With `en_x` low, port x neither reads nor writes on its edge and its outputs keep their previous value.
- R3: With `en_x` and `we_x` high, `din_x` and `dinx_x` are stored at `addr_x`. With `en_x` high and `we_x` low, the word at `addr_x` appears on the outputs one edge later.
- R4: A port in write-first mode (mode code 0) shows the word being written on its outputs after a write edge.
- R5: A port in read-first mode (mode code 1) shows the word held at the address before the write.
- R6: A port in no-change mode (mode code 2) keeps its outputs unchanged across every write edge.
- R7: With `en_x` and `sr_x` high, the outputs load the port's initial constant. This takes priority over the read, but a write in that cycle still updates the array.
- R8: The side-band bits take any pattern, including all ones and all zeros, and are returned unchanged with their data word.
- R9: A word written through one port is read back through the other port.
- R10: `coll_x` is high for the cycle after an edge at which port x was enabled while the other port wrote the same address, and low otherwise. When both ports write the same address together, the stored word is undefined.
- R11: The word count equals the data capacity divided by the data width (default 16384/32 = 512, 9 address bits). Address 0 and the top address are distinct locations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| sr_a | input | 1 | Port A output set/reset |
| addr_a | input | AW | Port A address |
| din_a | input | DATA_W | Port A write data |
| dinx_a | input | SIDE_W | Port A side-band write bits |
| dout_a | output | DATA_W | Port A registered read data |
| doutx_a | output | SIDE_W | Port A registered side-band bits |
| coll_a | output | 1 | Port A collision flag |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| sr_b | input | 1 | Port B output set/reset |
| addr_b | input | AW | Port B address |
| din_b | input | DATA_W | Port B write data |
| dinx_b | input | SIDE_W | Port B side-band write bits |
| dout_b | output | DATA_W | Port B registered read data |
| doutx_b | output | SIDE_W | Port B registered side-band bits |
| coll_b | output | 1 | Port B collision flag |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is set/reset and a write on the same port. The bench asserts `sr_a` together with `we_a`. It expects the initial constant on the output, then reads the address back and expects the written word, so the output took priority and the array was still updated. The second pair is a read on one port and a write on the other to the same address. The bench provokes it by reading on A while B writes the same location. It judges only the flags, high on A and low on B, and never checks the data read in that cycle.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wmode_t;
endpackage

// File: rtl/dpr_bank.sv
// Data storage written by exactly one port, read at both port addresses.
module dpr_bank #(
  parameter int W     = 36,
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr0,
  input  logic [AW-1:0] raddr1,
  output logic [W-1:0]  rdata0,
  output logic [W-1:0]  rdata1
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata0 = mem[raddr0];
  assign rdata1 = mem[raddr1];
endmodule

// File: rtl/dpr_lvt.sv
// One bit per word recording this writer's view of which bank is newest.
module dpr_lvt #(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic [AW-1:0] raddr0,
  input  logic [AW-1:0] raddr1,
  output logic          rbit0,
  output logic          rbit1
);
  logic [DEPTH-1:0] bits;

  always_ff @(posedge clk) begin
    if (rst) bits <= '0;
    else if (we) bits[waddr] <= wbit;
  end

  assign rbit0 = bits[raddr0];
  assign rbit1 = bits[raddr1];
endmodule

// File: rtl/dpr_port.sv
// Output register, write-mode selection, set/reset and collision flag of one port.
module dpr_port
  import dpr_pkg::*;
#(
  parameter int     W     = 36,
  parameter int     AW    = 9,
  parameter wmode_t MODE  = WM_WRITE_FIRST,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          we,
  input  logic          sr,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wword,
  input  logic [W-1:0]  rword,
  input  logic          o_en,
  input  logic          o_we,
  input  logic [AW-1:0] o_addr,
  output logic [W-1:0]  dout,
  output logic          coll
);
  logic [W-1:0] write_view;

  always_comb begin
    case (MODE)
      WM_WRITE_FIRST: write_view = wword;
      WM_READ_FIRST:  write_view = rword;
      default:        write_view = dout;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= INIT;
      coll <= 1'b0;
    end else begin
      coll <= en && o_en && o_we && (addr == o_addr);
      if (en) begin
        if (sr)      dout <= INIT;
        else if (we) dout <= write_view;
        else         dout <= rword;
      end
    end
  end
endmodule

// File: rtl/dual_port_mode_ram.sv
module dual_port_mode_ram
  import dpr_pkg::*;
#(
  parameter int     DATA_W        = 32,
  parameter int     SIDE_W        = 4,
  parameter int     DATA_CAPACITY = 16384,
  parameter wmode_t MODE_A        = WM_WRITE_FIRST,
  parameter wmode_t MODE_B        = WM_READ_FIRST,
  parameter logic [DATA_W+SIDE_W-1:0] INIT_A = 36'hA_5A5A_0F0F,
  parameter logic [DATA_W+SIDE_W-1:0] INIT_B = 36'h3_C3C3_1234,
  localparam int    DEPTH         = DATA_CAPACITY / DATA_W,
  localparam int    AW            = $clog2(DEPTH)
) (
  input  logic              clk_a,
  input  logic              rst_a,
  input  logic              en_a,
  input  logic              we_a,
  input  logic              sr_a,
  input  logic [AW-1:0]     addr_a,
  input  logic [DATA_W-1:0] din_a,
  input  logic [SIDE_W-1:0] dinx_a,
  output logic [DATA_W-1:0] dout_a,
  output logic [SIDE_W-1:0] doutx_a,
  output logic              coll_a,
  input  logic              clk_b,
  input  logic              rst_b,
  input  logic              en_b,
  input  logic              we_b,
  input  logic              sr_b,
  input  logic [AW-1:0]     addr_b,
  input  logic [DATA_W-1:0] din_b,
  input  logic [SIDE_W-1:0] dinx_b,
  output logic [DATA_W-1:0] dout_b,
  output logic [SIDE_W-1:0] doutx_b,
  output logic              coll_b
);
  localparam int WW = DATA_W + SIDE_W;

  logic          clk_v   [2];
  logic          rst_v   [2];
  logic          en_v    [2];
  logic          we_v    [2];
  logic          sr_v    [2];
  logic [AW-1:0] addr_v  [2];
  logic [WW-1:0] wword_v [2];
  logic [WW-1:0] rword_v [2];
  logic [WW-1:0] dout_v  [2];
  logic          coll_v  [2];
  logic [WW-1:0] bank_rd [2][2];
  logic          tog_rd  [2][2];

  assign clk_v[0]   = clk_a;
  assign clk_v[1]   = clk_b;
  assign rst_v[0]   = rst_a;
  assign rst_v[1]   = rst_b;
  assign en_v[0]    = en_a;
  assign en_v[1]    = en_b;
  assign we_v[0]    = we_a;
  assign we_v[1]    = we_b;
  assign sr_v[0]    = sr_a;
  assign sr_v[1]    = sr_b;
  assign addr_v[0]  = addr_a;
  assign addr_v[1]  = addr_b;
  assign wword_v[0] = {dinx_a, din_a};
  assign wword_v[1] = {dinx_b, din_b};

  for (genvar g = 0; g < 2; g++) begin : g_port
    localparam wmode_t        GMODE = (g == 0) ? MODE_A : MODE_B;
    localparam logic [WW-1:0] GINIT = (g == 0) ? INIT_A : INIT_B;
    logic wr;
    logic tog_new;

    assign wr = en_v[g] && we_v[g];
    // Writer 0 makes the bits equal, writer 1 makes them differ.
    if (g == 0) begin : g_eq
      assign tog_new = tog_rd[1][0];
    end else begin : g_ne
      assign tog_new = ~tog_rd[0][1];
    end

    dpr_bank #(.W(WW), .DEPTH(DEPTH), .AW(AW)) u_bank (
      .clk    (clk_v[g]),
      .we     (wr),
      .waddr  (addr_v[g]),
      .wdata  (wword_v[g]),
      .raddr0 (addr_v[0]),
      .raddr1 (addr_v[1]),
      .rdata0 (bank_rd[g][0]),
      .rdata1 (bank_rd[g][1])
    );

    dpr_lvt #(.DEPTH(DEPTH), .AW(AW)) u_lvt (
      .clk    (clk_v[g]),
      .rst    (rst_v[g]),
      .we     (wr),
      .waddr  (addr_v[g]),
      .wbit   (tog_new),
      .raddr0 (addr_v[0]),
      .raddr1 (addr_v[1]),
      .rbit0  (tog_rd[g][0]),
      .rbit1  (tog_rd[g][1])
    );

    assign rword_v[g] = (tog_rd[0][g] == tog_rd[1][g]) ? bank_rd[0][g] : bank_rd[1][g];

    dpr_port #(.W(WW), .AW(AW), .MODE(GMODE), .INIT(GINIT)) u_port (
      .clk    (clk_v[g]),
      .rst    (rst_v[g]),
      .en     (en_v[g]),
      .we     (we_v[g]),
      .sr     (sr_v[g]),
      .addr   (addr_v[g]),
      .wword  (wword_v[g]),
      .rword  (rword_v[g]),
      .o_en   (en_v[1-g]),
      .o_we   (we_v[1-g]),
      .o_addr (addr_v[1-g]),
      .dout   (dout_v[g]),
      .coll   (coll_v[g])
    );
  end

  assign {doutx_a, dout_a} = dout_v[0];
  assign {doutx_b, dout_b} = dout_v[1];
  assign coll_a = coll_v[0];
  assign coll_b = coll_v[1];
endmodule

// File: rtl/dpr_checker.sv
module dpr_checker
  import dpr_pkg::*;
#(
  parameter int     DATA_W = 32,
  parameter int     SIDE_W = 4,
  parameter int     AW     = 9,
  parameter wmode_t MODE_A = WM_WRITE_FIRST,
  parameter wmode_t MODE_B = WM_READ_FIRST,
  parameter logic [DATA_W+SIDE_W-1:0] INIT_A = '0,
  parameter logic [DATA_W+SIDE_W-1:0] INIT_B = '0
) (
  input logic              clk_a,
  input logic              rst_a,
  input logic              en_a,
  input logic              we_a,
  input logic              sr_a,
  input logic [AW-1:0]     addr_a,
  input logic [DATA_W-1:0] din_a,
  input logic [SIDE_W-1:0] dinx_a,
  input logic [DATA_W-1:0] dout_a,
  input logic [SIDE_W-1:0] doutx_a,
  input logic              coll_a,
  input logic              clk_b,
  input logic              rst_b,
  input logic              en_b,
  input logic              we_b,
  input logic              sr_b,
  input logic [AW-1:0]     addr_b,
  input logic [DATA_W-1:0] din_b,
  input logic [SIDE_W-1:0] dinx_b,
  input logic [DATA_W-1:0] dout_b,
  input logic [SIDE_W-1:0] doutx_b,
  input logic              coll_b
);
  // R2: idle port holds its outputs
  p_idle_hold_r2_a: assert property (@(posedge clk_a) disable iff (rst_a)
    !en_a |=> $stable({doutx_a, dout_a}));
  p_idle_hold_r2_b: assert property (@(posedge clk_b) disable iff (rst_b)
    !en_b |=> $stable({doutx_b, dout_b}));

  // R7: set/reset loads the initial constant
  p_sr_load_r7_a: assert property (@(posedge clk_a) disable iff (rst_a)
    (en_a && sr_a) |=> ({doutx_a, dout_a} == INIT_A));
  p_sr_load_r7_b: assert property (@(posedge clk_b) disable iff (rst_b)
    (en_b && sr_b) |=> ({doutx_b, dout_b} == INIT_B));

  // R4: write-first shows the written word
  p_wr_first_r4_a: assert property (@(posedge clk_a) disable iff (rst_a)
    (MODE_A == WM_WRITE_FIRST && en_a && we_a && !sr_a) |=>
      ({doutx_a, dout_a} == $past({dinx_a, din_a})));
  p_wr_first_r4_b: assert property (@(posedge clk_b) disable iff (rst_b)
    (MODE_B == WM_WRITE_FIRST && en_b && we_b && !sr_b) |=>
      ({doutx_b, dout_b} == $past({dinx_b, din_b})));

  // R6: no-change holds through a write
  p_no_change_r6_a: assert property (@(posedge clk_a) disable iff (rst_a)
    (MODE_A == WM_NO_CHANGE && en_a && we_a && !sr_a) |=> $stable({doutx_a, dout_a}));
  p_no_change_r6_b: assert property (@(posedge clk_b) disable iff (rst_b)
    (MODE_B == WM_NO_CHANGE && en_b && we_b && !sr_b) |=> $stable({doutx_b, dout_b}));

  // R10: collision flag follows same-address overlap
  p_coll_flag_r10_a: assert property (@(posedge clk_a) disable iff (rst_a)
    (en_a && en_b && we_b && addr_a == addr_b) |=> coll_a);
  p_coll_quiet_r10_a: assert property (@(posedge clk_a) disable iff (rst_a)
    !en_a |=> !coll_a);
  p_coll_flag_r10_b: assert property (@(posedge clk_b) disable iff (rst_b)
    (en_b && en_a && we_a && addr_a == addr_b) |=> coll_b);
  p_coll_quiet_r10_b: assert property (@(posedge clk_b) disable iff (rst_b)
    !en_b |=> !coll_b);
endmodule

bind dual_port_mode_ram dpr_checker #(
  .DATA_W (DATA_W),
  .SIDE_W (SIDE_W),
  .AW     (AW),
  .MODE_A (MODE_A),
  .MODE_B (MODE_B),
  .INIT_A (INIT_A),
  .INIT_B (INIT_B)
) u_chk (.*);

// File: tb/tb_dual_port_mode_ram.sv
module tb_dual_port_mode_ram;
  import dpr_pkg::*;

  localparam logic [35:0] IA = 36'hA_5A5A_0F0F;
  localparam logic [35:0] IB = 36'h3_C3C3_1234;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_a, en_a, we_a, sr_a, rst_b, en_b, we_b, sr_b;
  logic [8:0]  addr_a, addr_b;
  logic [31:0] din_a, din_b;
  logic [3:0]  dinx_a, dinx_b;
  logic [31:0] dout_a, dout_b, d2_a, d2_b;
  logic [3:0]  doutx_a, doutx_b, x2_a, x2_b;
  logic        coll_a, coll_b, c2_a, c2_b;

  int n_run  = 0;
  int n_fail = 0;

  dual_port_mode_ram dut (
    .clk_a(clk), .rst_a(rst_a), .en_a(en_a), .we_a(we_a), .sr_a(sr_a),
    .addr_a(addr_a), .din_a(din_a), .dinx_a(dinx_a),
    .dout_a(dout_a), .doutx_a(doutx_a), .coll_a(coll_a),
    .clk_b(clk), .rst_b(rst_b), .en_b(en_b), .we_b(we_b), .sr_b(sr_b),
    .addr_b(addr_b), .din_b(din_b), .dinx_b(dinx_b),
    .dout_b(dout_b), .doutx_b(doutx_b), .coll_b(coll_b));

  dual_port_mode_ram #(.MODE_A(WM_NO_CHANGE), .MODE_B(WM_WRITE_FIRST)) dut2 (
    .clk_a(clk), .rst_a(rst_a), .en_a(en_a), .we_a(we_a), .sr_a(sr_a),
    .addr_a(addr_a), .din_a(din_a), .dinx_a(dinx_a),
    .dout_a(d2_a), .doutx_a(x2_a), .coll_a(c2_a),
    .clk_b(clk), .rst_b(rst_b), .en_b(en_b), .we_b(we_b), .sr_b(sr_b),
    .addr_b(addr_b), .din_b(din_b), .dinx_b(dinx_b),
    .dout_b(d2_b), .doutx_b(x2_b), .coll_b(c2_b));

  // {we, addr, data, side, expected data, expected side} for port A (write-first)
  localparam logic [81:0] VEC [8] = '{
    {1'b1, 9'h000, 32'h1111_1111, 4'h1, 32'h1111_1111, 4'h1},
    {1'b1, 9'h1FF, 32'hDEAD_BEEF, 4'hF, 32'hDEAD_BEEF, 4'hF},
    {1'b1, 9'h055, 32'h0000_ABCD, 4'h0, 32'h0000_ABCD, 4'h0},
    {1'b0, 9'h000, 32'h0,         4'h0, 32'h1111_1111, 4'h1},
    {1'b0, 9'h1FF, 32'h0,         4'h0, 32'hDEAD_BEEF, 4'hF},
    {1'b1, 9'h000, 32'hCAFE_F00D, 4'h6, 32'hCAFE_F00D, 4'h6},
    {1'b0, 9'h055, 32'h0,         4'h0, 32'h0000_ABCD, 4'h0},
    {1'b0, 9'h000, 32'h0,         4'h0, 32'hCAFE_F00D, 4'h6}
  };

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic port_a(input logic en, input logic we, input logic sr,
                        input logic [8:0] ad, input logic [35:0] w);
    en_a = en; we_a = we; sr_a = sr; addr_a = ad; {dinx_a, din_a} = w;
  endtask

  task automatic port_b(input logic en, input logic we, input logic sr,
                        input logic [8:0] ad, input logic [35:0] w);
    en_b = en; we_b = we; sr_b = sr; addr_b = ad; {dinx_b, din_b} = w;
  endtask

  // one clock edge, then settle before sampling
  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_a = 1'b1; rst_b = 1'b1;
    port_a(1'b0, 1'b0, 1'b0, 9'h0, 36'h0);
    port_b(1'b0, 1'b0, 1'b0, 9'h0, 36'h0);
    tick(); tick();
    // R1: reset state
    chk("R1 dout_a", {doutx_a, dout_a}, IA);
    chk("R1 dout_b", {doutx_b, dout_b}, IB);
    chk("R1 coll", {34'h0, coll_a, coll_b}, 36'h0);
    @(negedge clk); rst_a = 1'b0; rst_b = 1'b0;

    // R3 R4 R8 R11: table walk on port A; dut2 port A is no-change (R6)
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      port_a(1'b1, VEC[i][81], 1'b0, VEC[i][80:72], {VEC[i][39:36], VEC[i][71:40]});
      tick();
      chk("R3/R4/R8/R11 table", {doutx_a, dout_a}, {VEC[i][3:0], VEC[i][35:4]});
      if (i == 0) chk("R6 nc first write", {x2_a, d2_a}, IA);
    end

    // R5: read-first on port B of dut; write-first on dut2 port B
    @(negedge clk);
    port_a(1'b0, 1'b0, 1'b0, 9'h0, 36'h0);
    port_b(1'b1, 1'b1, 1'b0, 9'h055, 36'h9_1234_5678);
    tick();
    chk("R5 read-first old word", {doutx_b, dout_b}, 36'h0_0000_ABCD);
    chk("R4 write-first port B", {x2_b, d2_b}, 36'h9_1234_5678);
    chk("R2 idle A holds", {doutx_a, dout_a}, 36'h6_CAFE_F00D);

    // R9: port A reads word written by B
    @(negedge clk);
    port_b(1'b0, 1'b0, 1'b0, 9'h0, 36'h0);
    port_a(1'b1, 1'b0, 1'b0, 9'h055, 36'h0);
    tick();
    chk("R9 B to A", {doutx_a, dout_a}, 36'h9_1234_5678);

    // R6: no-change on dut2 port A
    @(negedge clk); port_a(1'b1, 1'b0, 1'b0, 9'h1FF, 36'h0);
    tick();
    chk("R6 pre-read", {x2_a, d2_a}, 36'hF_DEAD_BEEF);
    @(negedge clk); port_a(1'b1, 1'b1, 1'b0, 9'h1FF, 36'h2_0102_0304);
    tick();
    chk("R6 no-change holds", {x2_a, d2_a}, 36'hF_DEAD_BEEF);
    chk("R4 write-first shows new", {doutx_a, dout_a}, 36'h2_0102_0304);

    // R9: port B reads word written by A
    @(negedge clk);
    port_a(1'b0, 1'b0, 1'b0, 9'h0, 36'h0);
    port_b(1'b1, 1'b0, 1'b0, 9'h1FF, 36'h0);
    tick();
    chk("R9 A to B", {doutx_b, dout_b}, 36'h2_0102_0304);

    // R2: disabled write is ignored
    @(negedge clk);
    port_b(1'b0, 1'b0, 1'b0, 9'h0, 36'h0);
    port_a(1'b0, 1'b1, 1'b0, 9'h000, 36'hF_FFFF_FFFF);
    tick();
    chk("R2 disabled holds", {doutx_a, dout_a}, 36'h2_0102_0304);
    @(negedge clk); port_a(1'b1, 1'b0, 1'b0, 9'h000, 36'h0);
    tick();
    chk("R2 no write stored", {doutx_a, dout_a}, 36'h6_CAFE_F00D);

    // R7: set/reset with a write in the same cycle
    @(negedge clk); port_a(1'b1, 1'b1, 1'b1, 9'h0AA, 36'h7_7777_7777);
    tick();
    chk("R7 sr over write", {doutx_a, dout_a}, IA);
    chk("R7 sr dut2", {x2_a, d2_a}, IA);
    @(negedge clk); port_a(1'b1, 1'b0, 1'b0, 9'h0AA, 36'h0);
    tick();
    chk("R7 write still stored", {doutx_a, dout_a}, 36'h7_7777_7777);
    @(negedge clk); port_a(1'b1, 1'b0, 1'b1, 9'h0AA, 36'h0);
    tick();
    chk("R7 sr over read", {doutx_a, dout_a}, IA);

    // R10: read on A while B writes the same address
    @(negedge clk);
    port_a(1'b1, 1'b0, 1'b0, 9'h100, 36'h0);
    port_b(1'b1, 1'b1, 1'b0, 9'h100, 36'h0);
    tick();
    chk("R10 coll_a raised", {35'h0, coll_a}, 36'h1);
    chk("R10 coll_b quiet", {35'h0, coll_b}, 36'h0);
    @(negedge clk);
    port_a(1'b1, 1'b0, 1'b0, 9'h000, 36'h0);
    port_b(1'b0, 1'b0, 1'b0, 9'h0, 36'h0);
    tick();
    chk("R10 coll_a cleared", {35'h0, coll_a}, 36'h0);

    // R1: reset in mid-run
    @(negedge clk); rst_a = 1'b1; rst_b = 1'b1;
    tick();
    chk("R1 mid-run A", {doutx_a, dout_a}, IA);
    chk("R1 mid-run B", {doutx_b, dout_b}, IB);
    @(negedge clk); rst_a = 1'b0; rst_b = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule